// File: doc/BRIEF.md
# SDR SDRAM Bring-Up and Refresh Sequencer

This block owns the command pins of one 16-bit single-data-rate SDRAM with a 12-bit row and 8-bit column address. Once reset is released it raises the clock enable and lets the device settle. It then walks a fixed bring-up order: one precharge of every bank, a burst of auto-refresh commands, and a load of the mode register. After that it declares the memory ready. In normal mode an internal interval timer requests maintenance. Each request becomes a short precharge-plus-refresh operation, and a busy flag marks its span so that a neighbouring access engine can keep off the bus.

All intervals are fixed at elaboration. Each nanosecond figure becomes clock cycles as (clock MHz × ns) / 1000, with truncating integer division. Any gap that rounds below one cycle is raised to one. Between any two commands the pins carry NOP.

Top module: `sdr_init_refresh`

## Requirements
- R1: While rst_n is low, sdr_cke is 0, sdr_cmd is NOP (4'b0111 on {CS_n,RAS_n,CAS_n,WE_n}), sdr_addr is 0, and init_done and refresh_busy are 0.
- R2: sdr_cke is 1 from the first rising edge after reset and stays 1. The command stays NOP for the power-up interval: 200 µs, which is 20000 cycles at 100 MHz, counted from that edge.
- R3: When the power-up interval ends, the block issues precharge-all: command 4'b0010 with sdr_addr bit 10 high and every other address bit low.
- R4: Initialization issues exactly 8 auto-refresh commands (4'b0001). The first follows the precharge by tRP, and each of the others follows the previous one by tRFC (60 ns, which is 6 cycles).
- R5: The mode-register set (4'b0000) comes tRFC after the last initial refresh. It drives burst-length code 0 (burst of one) in address bits 2:0 and CAS latency 3 in bits 6:4, so sdr_addr is 12'h030.
- R6: init_done rises one mode-register gap (1 cycle) after the mode-register set. It then stays high until the next reset.
- R7: In normal mode, a maintenance operation begins REF cycles after init_done rises, and again REF cycles after each maintenance operation ends. REF = trunc(MHz × (64 ms / 8192 in ns) / 1000) − 20, which is 761 at 100 MHz.
- R8: A maintenance operation is precharge-all, then one auto-refresh tRP later. refresh_busy is high from the precharge cycle through tRFC after the refresh, for tRP + tRFC cycles.
- R9: In every cycle that carries no command, sdr_cmd is NOP and sdr_addr is 0.
- R10: Gaps use truncating conversion. tRP = 18 ns at 100 MHz gives 1 cycle, so the first refresh comes in the cycle right after the precharge.
- R11: A reset asserted in normal mode returns all outputs to the R1 state, and the whole bring-up sequence repeats after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdr_cke | output | 1 | SDRAM clock enable |
| sdr_cmd | output | 4 | Command as {CS_n, RAS_n, CAS_n, WE_n} |
| sdr_addr | output | 12 | Address lines (A10 for precharge-all, mode value for mode set) |
| init_done | output | 1 | High once bring-up has finished |
| refresh_busy | output | 1 | High during a normal-mode maintenance operation |

## Verification
The bench targets the cycle-exact edges of the sequence. These are the last NOP before the precharge, the one-cycle tRP gap that truncation produces, the eighth refresh against a missing or extra ninth, and the single cycle between the mode set and init_done. A design that counted the refresh burst off by one, or rounded up instead of truncating, would put a command one or more cycles away from the reference. Two further targets are the reload of the interval timer from the end of each maintenance operation and a reset taken in normal mode. A design that reloaded on the precharge would drift its period by tRP + tRFC. A design that kept state across reset would skip the bring-up.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // Command on {CS_n, RAS_n, CAS_n, WE_n}
    typedef enum logic [3:0] {
        CMD_MRS  = 4'b0000,
        CMD_AREF = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_NOP  = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP,   // settle wait, then precharge-all
        ST_AREF,    // initial refresh burst
        ST_MRS,     // mode-register load
        ST_FIN,     // mode-set gap, then ready
        ST_RUN,     // normal mode, waiting on timer
        ST_RAREF,   // maintenance: refresh after precharge
        ST_REND     // maintenance: refresh recovery
    } seq_state_e;

    // R10: truncating nanosecond to cycle conversion
    function automatic int ns_to_clk(input int mhz, input int ns);
        return (mhz * ns) / 1000;
    endfunction

    function automatic int gap_clk(input int mhz, input int ns);
        int c;
        c = ns_to_clk(mhz, ns);
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int RELOAD = 761,
    parameter int W      = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);

    logic [W-1:0] tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load)
            tmr_d = W'(RELOAD - 1);
        else if (run && tmr_q != '0)
            tmr_d = tmr_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= W'(RELOAD - 1);
        else        tmr_q <= tmr_d;
    end

    assign zero = (tmr_q == '0);

endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
    import sdr_seq_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int PWRUP_NS     = 200000,
    parameter int TRP_NS       = 18,
    parameter int TRFC_NS      = 60,
    parameter int TMRD_CLK     = 1,
    parameter int INIT_AREF    = 8,
    parameter int CAS_LAT      = 3,
    parameter int BURST_CODE   = 0,
    parameter int ROW_W        = 12,
    parameter int REF_WIN_NS   = 64000000,
    parameter int REF_ROWS     = 8192,
    parameter int REF_MARGIN   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sdr_cke,
    output logic [3:0]       sdr_cmd,
    output logic [ROW_W-1:0] sdr_addr,
    output logic             init_done,
    output logic             refresh_busy
);

    localparam int PWRUP_CLK = gap_clk(CLK_MHZ, PWRUP_NS);
    localparam int TRP_CLK   = gap_clk(CLK_MHZ, TRP_NS);
    localparam int TRFC_CLK  = gap_clk(CLK_MHZ, TRFC_NS);
    localparam int MRD_CLK   = (TMRD_CLK < 1) ? 1 : TMRD_CLK;
    localparam int REF_CLK   = ns_to_clk(CLK_MHZ, REF_WIN_NS / REF_ROWS) - REF_MARGIN;
    localparam int CNT_W     = $clog2(PWRUP_CLK + 1);
    localparam int LEFT_W    = $clog2(INIT_AREF + 1);
    localparam int TMR_W     = $clog2(REF_CLK + 1);

    localparam logic [CNT_W-1:0]  TRP_LD    = CNT_W'(TRP_CLK - 1);
    localparam logic [CNT_W-1:0]  TRFC_LD   = CNT_W'(TRFC_CLK - 1);
    localparam logic [CNT_W-1:0]  MRD_LD    = CNT_W'(MRD_CLK - 1);
    localparam logic [LEFT_W-1:0] LEFT_INIT = LEFT_W'(INIT_AREF - 1);
    localparam logic [ROW_W-1:0]  ALL_BANKS = ROW_W'(1) << 10;
    localparam logic [ROW_W-1:0]  MODE_WORD = ROW_W'((CAS_LAT << 4) | BURST_CODE);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [LEFT_W-1:0] left;
        logic              cke;
        sdr_cmd_e          cmd;
        logic [ROW_W-1:0]  addr;
        logic              done;
        logic              busy;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        st: ST_PWRUP, cnt: CNT_W'(PWRUP_CLK), left: LEFT_INIT, cke: 1'b0,
        cmd: CMD_NOP, addr: '0, done: 1'b0, busy: 1'b0
    };

    seq_regs_t r_d, r_q;
    logic      tmr_load, tmr_run, tmr_zero;

    sdr_refresh_timer #(
        .RELOAD (REF_CLK),
        .W      (TMR_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (tmr_run),
        .zero  (tmr_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cke  = 1'b1;
        r_d.cmd  = CMD_NOP;
        r_d.addr = '0;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        if (r_q.cnt != '0)
            r_d.cnt = r_q.cnt - 1'b1;

        case (r_q.st)
            ST_PWRUP: if (r_q.cnt == '0) begin
                r_d.cmd  = CMD_PRE;
                r_d.addr = ALL_BANKS;
                r_d.cnt  = TRP_LD;
                r_d.left = LEFT_INIT;
                r_d.st   = ST_AREF;
            end
            ST_AREF: if (r_q.cnt == '0) begin
                r_d.cmd = CMD_AREF;
                r_d.cnt = TRFC_LD;
                if (r_q.left == '0) r_d.st   = ST_MRS;
                else                r_d.left = r_q.left - 1'b1;
            end
            ST_MRS: if (r_q.cnt == '0) begin
                r_d.cmd  = CMD_MRS;
                r_d.addr = MODE_WORD;
                r_d.cnt  = MRD_LD;
                r_d.st   = ST_FIN;
            end
            ST_FIN: if (r_q.cnt == '0) begin
                r_d.done = 1'b1;
                tmr_load = 1'b1;
                r_d.st   = ST_RUN;
            end
            ST_RUN: begin
                tmr_run = 1'b1;
                if (tmr_zero) begin
                    r_d.cmd  = CMD_PRE;
                    r_d.addr = ALL_BANKS;
                    r_d.busy = 1'b1;
                    r_d.cnt  = TRP_LD;
                    r_d.st   = ST_RAREF;
                end
            end
            ST_RAREF: if (r_q.cnt == '0) begin
                r_d.cmd = CMD_AREF;
                r_d.cnt = TRFC_LD;
                r_d.st  = ST_REND;
            end
            ST_REND: if (r_q.cnt == '0) begin
                r_d.busy = 1'b0;
                tmr_load = 1'b1;
                r_d.st   = ST_RUN;
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign sdr_cke      = r_q.cke;
    assign sdr_cmd      = r_q.cmd;
    assign sdr_addr     = r_q.addr;
    assign init_done    = r_q.done;
    assign refresh_busy = r_q.busy;

    // Precharge always targets every bank
    assert_pre_all_banks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cmd == CMD_PRE) |-> sdr_addr[10]);

    // Clock enable never drops once raised
    assert_cke_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sdr_cke |=> sdr_cke);

    // No mode-register load once ready
    assert_no_mrs_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (sdr_cmd != CMD_MRS));

    // Ready flag is sticky
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // Maintenance only happens in normal mode
    assert_busy_after_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_busy |-> init_done);

    // Idle cycles carry a clean bus
    assert_nop_quiet_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cmd == CMD_NOP) |-> (sdr_addr == '0));

endmodule

// File: tb/sdr_init_refresh_test.sv
module sdr_init_refresh_test;

    localparam int MHZ  = 100;
    localparam int P0   = (MHZ * 200000) / 1000;               // 20000
    localparam int TRP  = ((MHZ * 18) / 1000 < 1) ? 1 : (MHZ * 18) / 1000;
    localparam int TRFC = (MHZ * 60) / 1000;
    localparam int TMRD = 1;
    localparam int NREF = 8;
    localparam int REF  = (MHZ * (64000000 / 8192)) / 1000 - 20; // 761
    localparam int A0   = P0 + TRP;
    localparam int M    = A0 + NREF * TRFC;
    localparam int F    = M + TMRD;
    localparam int T    = REF + TRP + TRFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdr_cke;
    logic [3:0]  sdr_cmd;
    logic [11:0] sdr_addr;
    logic        init_done;
    logic        refresh_busy;

    int checks = 0;
    int fails  = 0;
    int kk     = -1;
    int cycles = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    sdr_init_refresh uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sdr_cke      (sdr_cke),
        .sdr_cmd      (sdr_cmd),
        .sdr_addr     (sdr_addr),
        .init_done    (init_done),
        .refresh_busy (refresh_busy)
    );

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) kk = -1;
        else        kk++;
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at edge %0d: actual %0h expected %0h", tag, what, kk, act, exp);
        end
    endtask

    // Behavioural reference: expected outputs after edge k
    always @(negedge clk) begin
        int  k, ecmd, eaddr, ecke, edone, ebusy, j, ph;
        string tag;
        k = kk;
        ecke = 1; ecmd = 4'b0111; eaddr = 0; edone = 0; ebusy = 0; tag = "R2";
        if (k < 0) begin
            ecke = 0; tag = (cycles > F) ? "R11" : "R1";
        end else if (k == P0) begin
            ecmd = 4'b0010; eaddr = 12'h400; tag = "R3";
        end else if (k > P0 && k < M) begin
            tag = "R4";
            if ((k - A0) % TRFC == 0) begin
                ecmd = 4'b0001;
                if (k == A0) tag = "R10";
            end else tag = "R9";
        end else if (k == M) begin
            ecmd = 4'b0000; eaddr = 12'h030; tag = "R5";
        end else if (k > M && k <= F) begin
            tag = "R6";
            edone = (k >= F) ? 1 : 0;
        end else if (k > F) begin
            edone = 1; tag = "R7";
            j = k - F - REF;
            if (j >= 0) begin
                ph = j % T;
                if (ph < TRP + TRFC) begin
                    ebusy = 1; tag = "R8";
                    if (ph == 0)   begin ecmd = 4'b0010; eaddr = 12'h400; end
                    if (ph == TRP) ecmd = 4'b0001;
                end
            end
        end
        check(tag, "cke", sdr_cke, ecke);
        check(tag, "cmd", sdr_cmd, ecmd);
        check(tag, "addr", sdr_addr, eaddr);
        check(tag, "init_done", init_done, edone);
        check(tag, "refresh_busy", refresh_busy, ebusy);
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;                        // R2 timeline starts next edge
        wait (kk == F + 3 * T + 20);
        @(negedge clk);
        rst_n = 1'b0;                        // R11: reset in normal mode
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait (kk == F + 40);
        @(negedge clk);
        finish_run();
    end

endmodule